// File: doc/BRIEF.md
# Interlace-Capable Video Timing Generator

This block produces the raster timing for one display output: an active-high horizontal sync, an active-high vertical sync, a data-enable window, a field indicator, and a pixel-advance strobe that tells the pixel path when to pull the next pixel from its FIFO. Software programs horizontal and vertical segment lengths through a simple word-addressed write/read port. The segment lengths count output clocks and already include any pixel repetition. A second vertical segment set serves the even field of interlaced modes. A programmable sub-line delay moves the vertical sync of each field.

Every timing value is copied into a shadow set at the first clock of each frame or field, so register writes never produce a frame that mixes old and new values. The generator runs either continuously or for one frame. Clearing the video enable stops it at the end of the current frame, and the enable bit keeps reading as 1 until the generator has actually stopped. A status bit is raised at the first clock of the vertical front porch; it can drive the interrupt line and is cleared by writing 1. The block also compares the FIFO fill level against a threshold chosen by the pixel format, and issues FIFO flush pulses.

Top module: `video_timing_gen`

## Requirements
- R1: Each line is, in order, `sync` clocks with `hsync`=1, then `back` clocks, then `act` clocks, then `front` clocks. The horizontal fields are taken from the shadow set. Every segment length must be at least 1.
- R2: Each frame or field has vertical segments in the same order (sync, back, act, front), counted in lines. `de` is 1 only when both the line position and the line number are inside their active segments.
- R3: In interlace mode, fields alternate, and the first field after a start is odd (`field`=0). The odd field uses the primary vertical set and the odd delay. The even field uses the even set and the even delay. `vsync` rises that many clocks after the field start and lasts `vsync` lines; the delay must be smaller than the line length. With interlace off, `field` is 0, the primary set is used and the delay is 0.
- R4: `pix_adv` pulses on the first active clock of each line and then every (rep+1) active clocks, where rep is the repeat-factor-minus-one field latched at frame start.
- R5: A frame starts from idle when video enable and master enable are both 1. At the end of a frame, the next frame starts at once if video enable, continuous mode and master enable are all 1. Otherwise the generator stops and hardware clears video enable, so that continuous mode off gives exactly one frame.
- R6: Bit 0 of the video-control word reads 1 while video enable is set or while a frame is still running. After software clears video enable, it reads 0 only once the current frame has ended and all outputs are idle.
- R7: At the first clock of the vertical front porch, the status bit (word 10, bit 0) is set one cycle later. `irq` = status AND enable (word 9, bit 0). Writing 1 to word 10 bit 0 clears the status, but a set in the same cycle wins.
- R8: Writes to timing, delay, interlace and repeat fields take effect only at the next frame or field start.
- R9: `fifo_full` = `fifo_level` >= 64 minus a margin. The margin follows the format field: format 0 (16-bit) uses 12, format 1 (18-bit) uses 14, and formats 2 and 3 (24-bit) use 18.
- R10: `fifo_flush` pulses for one cycle in the cycle after a control-word write that has bit 0 and bit 1 both set. It also pulses in the cycle after every frame start when clear-at-start (control bit 2) is set.
- R11: After reset, all registers are 0, the generator is idle and every output is 0.
- R12: Word map (the low field sits at [11:0], the high field at [27:16]):
  - 0 = control: bit 0 master enable, bit 1 FIFO clear (write-only), bit 2 clear-at-start, [5:4] format, [9:8] rep.
  - 1 = video control: bit 0 video enable, bit 1 continuous, bit 2 interlace, high field = odd delay.
  - 2/3 = horizontal sync, back / act, front.
  - 4/5 = primary vertical sync, back / act, front.
  - 6/7 = even vertical sync, back / act, front.
  - 8 = even delay (low field).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fifo_level | input | 7 | Current pixel FIFO fill level |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active video window |
| field | output | 1 | 0 = odd field, 1 = even field |
| pix_adv | output | 1 | Fetch-next-pixel strobe |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| fifo_full | output | 1 | FIFO level has reached the format threshold |
| irq | output | 1 | Front-porch-start interrupt |

## Verification
The timing outputs are compared every cycle against a model that tracks a linear position within the frame, across several input patterns:
- A progressive continuous raster with distinct segment lengths exposes any swapped or misordered segment.
- A mid-frame width change separates shadowed from live timing.
- Repeat factor 2 tells the strobe spacing apart from the data-enable width.
- An interlaced run with unequal field back porches and a non-zero odd delay shows whether the field sets alternate and whether the sync is shifted within the line.

Single-shot runs and an enable withdrawn mid-frame show the difference between stopping at the frame end and stopping at once. Thresholds are probed one level below and exactly at each format's limit.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TIM_W  = 12;
  localparam int unsigned HI_LSB = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_VCTRL = 4'd1;
  localparam logic [ADDR_W-1:0] A_SEG0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EDLY  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IRQEN = 4'd9;
  localparam logic [ADDR_W-1:0] A_IRQST = 4'd10;

  typedef struct packed {
    logic [TIM_W-1:0] sync;
    logic [TIM_W-1:0] back;
    logic [TIM_W-1:0] act;
    logic [TIM_W-1:0] front;
  } seg_t;

  typedef struct packed {
    seg_t             h;
    seg_t             v;
    logic [TIM_W-1:0] dly;
  } shadow_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned REP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              running_i,
  input  logic              stop_i,
  input  logic              vfp_start_i,
  output logic              master_o,
  output logic              clras_o,
  output logic [1:0]        fmt_o,
  output logic [REP_W-1:0]  rep_o,
  output logic              en_req_o,
  output logic              cont_o,
  output logic              lace_o,
  output logic [TIM_W-1:0]  odly_o,
  output logic [TIM_W-1:0]  edly_o,
  output seg_t              hcfg_o,
  output seg_t              vodd_o,
  output seg_t              vevn_o,
  output logic              clr_req_o,
  output logic              irq_o
);
  localparam int unsigned NSEG = 3;

  logic wr_ctrl, wr_vctrl, wr_edly, wr_irqen, wr_irqst;
  logic en_q, en_d, st_q, st_d, irqen_q;
  logic master_q, clras_q, cont_q, lace_q;
  logic [1:0]       fmt_q;
  logic [REP_W-1:0] rep_q;
  logic [TIM_W-1:0] odly_q, edly_q;
  seg_t             seg_q [NSEG];
  logic             unused_wd;

  assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
  assign wr_vctrl = wr_i && (addr_i == A_VCTRL);
  assign wr_edly  = wr_i && (addr_i == A_EDLY);
  assign wr_irqen = wr_i && (addr_i == A_IRQEN);
  assign wr_irqst = wr_i && (addr_i == A_IRQST);
  assign unused_wd = ^wdata_i;

  // next state: hardware stop clears the enable, a write overrides it
  always_comb begin
    en_d = en_q;
    if (stop_i)   en_d = 1'b0;
    if (wr_vctrl) en_d = wdata_i[0];
    st_d = st_q;
    if (wr_irqst && wdata_i[0]) st_d = 1'b0;
    if (vfp_start_i)            st_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      clras_q  <= 1'b0;
      fmt_q    <= '0;
      rep_q    <= '0;
    end else if (wr_ctrl) begin
      master_q <= wdata_i[0];
      clras_q  <= wdata_i[2];
      fmt_q    <= wdata_i[5:4];
      rep_q    <= wdata_i[8 +: REP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      lace_q <= 1'b0;
      odly_q <= '0;
    end else if (wr_vctrl) begin
      cont_q <= wdata_i[1];
      lace_q <= wdata_i[2];
      odly_q <= wdata_i[HI_LSB +: TIM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        edly_q <= '0;
    else if (wr_edly)  edly_q <= wdata_i[TIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irqen_q <= 1'b0;
    else if (wr_irqen) irqen_q <= wdata_i[0];
  end

  // one two-word group per segment set: horizontal, primary vertical, even vertical
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [ADDR_W-1:0] A_LO = A_SEG0 + ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] A_HI = A_SEG0 + ADDR_W'(2 * g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (wr_i && (addr_i == A_LO)) begin
        seg_q[g].sync <= wdata_i[TIM_W-1:0];
        seg_q[g].back <= wdata_i[HI_LSB +: TIM_W];
      end else if (wr_i && (addr_i == A_HI)) begin
        seg_q[g].act   <= wdata_i[TIM_W-1:0];
        seg_q[g].front <= wdata_i[HI_LSB +: TIM_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[0]           = master_q;
        rdata_o[2]           = clras_q;
        rdata_o[5:4]         = fmt_q;
        rdata_o[8 +: REP_W]  = rep_q;
      end
      A_VCTRL: begin
        rdata_o[0]                = en_q | running_i;
        rdata_o[1]                = cont_q;
        rdata_o[2]                = lace_q;
        rdata_o[HI_LSB +: TIM_W]  = odly_q;
      end
      A_EDLY:  rdata_o[TIM_W-1:0] = edly_q;
      A_IRQEN: rdata_o[0]         = irqen_q;
      A_IRQST: rdata_o[0]         = st_q;
      default: begin
        for (int k = 0; k < NSEG; k++) begin
          if (addr_i == A_SEG0 + ADDR_W'(2 * k)) begin
            rdata_o[TIM_W-1:0]       = seg_q[k].sync;
            rdata_o[HI_LSB +: TIM_W] = seg_q[k].back;
          end else if (addr_i == A_SEG0 + ADDR_W'(2 * k + 1)) begin
            rdata_o[TIM_W-1:0]       = seg_q[k].act;
            rdata_o[HI_LSB +: TIM_W] = seg_q[k].front;
          end
        end
      end
    endcase
  end

  assign master_o  = master_q;
  assign clras_o   = clras_q;
  assign fmt_o     = fmt_q;
  assign rep_o     = rep_q;
  assign en_req_o  = en_q;
  assign cont_o    = cont_q;
  assign lace_o    = lace_q;
  assign odly_o    = odly_q;
  assign edly_o    = edly_q;
  assign hcfg_o    = seg_q[0];
  assign vodd_o    = seg_q[1];
  assign vevn_o    = seg_q[2];
  assign clr_req_o = wr_ctrl && wdata_i[0] && wdata_i[1];
  assign irq_o     = st_q & irqen_q;

  // R7
  frontporch_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfp_start_i |=> st_q);
  // R6
  stop_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_vctrl) |=> !en_q);
endmodule

// File: rtl/vtg_scan.sv
module vtg_scan
  import vtg_pkg::*;
#(
  parameter int unsigned REP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req_i,
  input  logic             master_i,
  input  logic             cont_i,
  input  logic             lace_i,
  input  seg_t             hcfg_i,
  input  seg_t             vodd_i,
  input  seg_t             vevn_i,
  input  logic [TIM_W-1:0] odly_i,
  input  logic [TIM_W-1:0] edly_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             field_o,
  output logic             run_o,
  output logic             stop_o,
  output logic             load_o,
  output logic             vfp_start_o,
  output logic [REP_W-1:0] rep_o
);
  localparam int unsigned CNT_W = TIM_W + 2;

  logic             run_q, run_d, field_q, field_d, load, stop;
  logic [CNT_W-1:0] hcnt_q, hcnt_d, vcnt_q, vcnt_d;
  shadow_t          sh_q, sh_d;
  logic [REP_W-1:0] rep_q;
  logic [CNT_W-1:0] htot, vtot, h_act0, h_act1, v_act0, v_act1, v_fp0, v_sy, dly;

  assign h_act0 = CNT_W'(sh_q.h.sync) + CNT_W'(sh_q.h.back);
  assign h_act1 = h_act0 + CNT_W'(sh_q.h.act);
  assign htot   = h_act1 + CNT_W'(sh_q.h.front);
  assign v_sy   = CNT_W'(sh_q.v.sync);
  assign v_act0 = v_sy + CNT_W'(sh_q.v.back);
  assign v_act1 = v_act0 + CNT_W'(sh_q.v.act);
  assign v_fp0  = v_act1;
  assign vtot   = v_act1 + CNT_W'(sh_q.v.front);
  assign dly    = CNT_W'(sh_q.dly);

  // next state of the raster position and the frame sequencing
  always_comb begin
    load    = 1'b0;
    stop    = 1'b0;
    run_d   = run_q;
    hcnt_d  = hcnt_q;
    vcnt_d  = vcnt_q;
    field_d = field_q;
    if (!run_q) begin
      if (en_req_i && master_i) begin
        load    = 1'b1;
        run_d   = 1'b1;
        hcnt_d  = '0;
        vcnt_d  = '0;
        field_d = 1'b0;
      end
    end else if (hcnt_q == htot - 1'b1) begin
      hcnt_d = '0;
      if (vcnt_q == vtot - 1'b1) begin
        vcnt_d = '0;
        if (en_req_i && cont_i && master_i) begin
          load    = 1'b1;
          field_d = lace_i ? ~field_q : 1'b0;
        end else begin
          stop  = 1'b1;
          run_d = 1'b0;
        end
      end else begin
        vcnt_d = vcnt_q + 1'b1;
      end
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_comb begin
    sh_d.h   = hcfg_i;
    sh_d.v   = field_d ? vevn_i : vodd_i;
    sh_d.dly = lace_i ? (field_d ? edly_i : odly_i) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      field_q <= 1'b0;
      hcnt_q  <= '0;
      vcnt_q  <= '0;
    end else begin
      run_q   <= run_d;
      field_q <= field_d;
      hcnt_q  <= hcnt_d;
      vcnt_q  <= vcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rep_q <= '0;
    end else if (load) begin
      sh_q  <= sh_d;
      rep_q <= rep_i;
    end
  end

  assign hsync_o     = run_q && (hcnt_q < CNT_W'(sh_q.h.sync));
  assign vsync_o     = run_q && (((vcnt_q < v_sy) && !((vcnt_q == '0) && (hcnt_q < dly)))
                              || ((vcnt_q == v_sy) && (hcnt_q < dly)));
  assign de_o        = run_q && (hcnt_q >= h_act0) && (hcnt_q < h_act1)
                             && (vcnt_q >= v_act0) && (vcnt_q < v_act1);
  assign vfp_start_o = run_q && (hcnt_q == '0) && (vcnt_q == v_fp0);
  assign field_o     = field_q;
  assign run_o       = run_q;
  assign stop_o      = stop;
  assign load_o      = load;
  assign rep_o       = rep_q;

  // R1
  sync_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_o |-> !de_o);
  // R2
  porch_start_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfp_start_o |-> !de_o);
  // R5
  idle_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !(hsync_o || vsync_o || de_o));
  // R3
  progressive_odd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !lace_i) |=> !field_q);
endmodule

// File: rtl/vtg_pix.sv
module vtg_pix #(
  parameter int unsigned REP_W      = 2,
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic [1:0]       fmt_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             clr_req_i,
  input  logic             load_i,
  input  logic             clras_i,
  output logic             pix_adv_o,
  output logic             fifo_full_o,
  output logic             fifo_flush_o
);
  localparam int unsigned MARGIN_16 = 12;
  localparam int unsigned MARGIN_18 = 14;
  localparam int unsigned MARGIN_24 = 18;
  localparam logic [LVL_W-1:0] THR_16 = LVL_W'(FIFO_BYTES - MARGIN_16);
  localparam logic [LVL_W-1:0] THR_18 = LVL_W'(FIFO_BYTES - MARGIN_18);
  localparam logic [LVL_W-1:0] THR_24 = LVL_W'(FIFO_BYTES - MARGIN_24);

  logic [REP_W-1:0] rc_q, rc_d;
  logic             flush_q, flush_d;
  logic [LVL_W-1:0] thr;

  always_comb begin
    case (fmt_i)
      2'd0:    thr = THR_16;
      2'd1:    thr = THR_18;
      default: thr = THR_24;
    endcase
  end

  always_comb begin
    if (!de_i)             rc_d = '0;
    else if (rc_q == rep_i) rc_d = '0;
    else                    rc_d = rc_q + 1'b1;
    flush_d = clr_req_i || (load_i && clras_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      rc_q    <= rc_d;
      flush_q <= flush_d;
    end
  end

  assign pix_adv_o    = de_i && (rc_q == '0);
  assign fifo_full_o  = fifo_level_i >= thr;
  assign fifo_flush_o = flush_q;

  // R4
  advance_inside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_adv_o |-> de_i);
  // R9
  full_above_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full_o |-> (fifo_level_i >= THR_24));
  // R10
  flush_after_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req_i |=> fifo_flush_o);
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned REP_W      = 2,
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              field,
  output logic              pix_adv,
  output logic              fifo_flush,
  output logic              fifo_full,
  output logic              irq
);
  logic             running, stop, load, vfp_start, clr_req;
  logic             master, clras, en_req, cont, lace;
  logic [1:0]       fmt;
  logic [REP_W-1:0] rep_live, rep_sh;
  logic [TIM_W-1:0] odly, edly;
  seg_t             hcfg, vodd, vevn;

  vtg_regs #(.REP_W(REP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .rdata_o(reg_rdata), .running_i(running), .stop_i(stop), .vfp_start_i(vfp_start),
    .master_o(master), .clras_o(clras), .fmt_o(fmt), .rep_o(rep_live),
    .en_req_o(en_req), .cont_o(cont), .lace_o(lace), .odly_o(odly), .edly_o(edly),
    .hcfg_o(hcfg), .vodd_o(vodd), .vevn_o(vevn), .clr_req_o(clr_req), .irq_o(irq)
  );

  vtg_scan #(.REP_W(REP_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .master_i(master), .cont_i(cont),
    .lace_i(lace), .hcfg_i(hcfg), .vodd_i(vodd), .vevn_i(vevn), .odly_i(odly),
    .edly_i(edly), .rep_i(rep_live), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .field_o(field), .run_o(running), .stop_o(stop), .load_o(load),
    .vfp_start_o(vfp_start), .rep_o(rep_sh)
  );

  vtg_pix #(.REP_W(REP_W), .FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .de_i(de), .rep_i(rep_sh), .fmt_i(fmt),
    .fifo_level_i(fifo_level), .clr_req_i(clr_req), .load_i(load), .clras_i(clras),
    .pix_adv_o(pix_adv), .fifo_full_o(fifo_full), .fifo_flush_o(fifo_flush)
  );
endmodule

// File: tb/video_timing_gen_tb.sv
`timescale 1ns/1ps
module video_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  level = '0;
  logic hsync, vsync, de, field, pix_adv, flush, full, irq;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 1'b0;

  video_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .fifo_level(level), .hsync(hsync), .vsync(vsync), .de(de),
    .field(field), .pix_adv(pix_adv), .fifo_flush(flush), .fifo_full(full), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_master, m_clras, m_fmt, m_rep, m_en, m_cont, m_lace, m_odly, m_edly;
  int m_irqen, m_irqst, m_run, m_pos, m_field, m_flush;
  int m_ht[4], m_vo[4], m_ve[4], sh_h[4], sh_v[4], sh_dly, sh_rep;

  function automatic int hsum(); return sh_h[0] + sh_h[1] + sh_h[2] + sh_h[3]; endfunction
  function automatic int vsum(); return sh_v[0] + sh_v[1] + sh_v[2] + sh_v[3]; endfunction
  function automatic bit at_vfp();
    return m_run != 0 && m_pos == (sh_v[0] + sh_v[1] + sh_v[2]) * hsum();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_master = 0; m_clras = 0; m_fmt = 0; m_rep = 0; m_en = 0; m_cont = 0;
      m_lace = 0; m_odly = 0; m_edly = 0; m_irqen = 0; m_irqst = 0; m_run = 0;
      m_pos = 0; m_field = 0; m_flush = 0;
      for (int i = 0; i < 4; i++) begin m_ht[i] = 0; m_vo[i] = 0; m_ve[i] = 0; end
    end else begin
      automatic bit vfp = at_vfp();
      automatic bit do_load = 0;
      automatic bit stop = 0;
      automatic int nf = 0;
      if (m_run == 0) begin
        if (m_en != 0 && m_master != 0) begin do_load = 1; nf = 0; end
      end else if (m_pos == hsum() * vsum() - 1) begin
        if (m_en != 0 && m_cont != 0 && m_master != 0) begin
          do_load = 1; nf = (m_lace != 0) ? 1 - m_field : 0;
        end else begin
          m_run = 0; stop = 1;
        end
      end else m_pos++;
      m_flush = ((wr && addr == 0 && wdata[0] && wdata[1]) || (do_load && m_clras != 0)) ? 1 : 0;
      if (do_load) begin
        m_run = 1; m_pos = 0; m_field = nf;
        sh_h = m_ht;
        sh_v = (nf != 0) ? m_ve : m_vo;
        sh_dly = (m_lace != 0) ? ((nf != 0) ? m_edly : m_odly) : 0;
        sh_rep = m_rep;
      end
      if (stop) m_en = 0;
      if (wr && addr == 10 && wdata[0]) m_irqst = 0;
      if (vfp) m_irqst = 1;
      if (wr) begin
        case (addr)
          0: begin m_master = wdata[0]; m_clras = wdata[2]; m_fmt = wdata[5:4]; m_rep = wdata[9:8]; end
          1: begin m_en = wdata[0]; m_cont = wdata[1]; m_lace = wdata[2]; m_odly = wdata[27:16]; end
          2: begin m_ht[0] = wdata[11:0]; m_ht[1] = wdata[27:16]; end
          3: begin m_ht[2] = wdata[11:0]; m_ht[3] = wdata[27:16]; end
          4: begin m_vo[0] = wdata[11:0]; m_vo[1] = wdata[27:16]; end
          5: begin m_vo[2] = wdata[11:0]; m_vo[3] = wdata[27:16]; end
          6: begin m_ve[0] = wdata[11:0]; m_ve[1] = wdata[27:16]; end
          7: begin m_ve[2] = wdata[11:0]; m_ve[3] = wdata[27:16]; end
          8: m_edly = wdata[11:0];
          9: m_irqen = wdata[0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      automatic bit e_hs = 0, e_vs = 0, e_de = 0, e_pix = 0;
      if (m_run != 0) begin
        automatic int ht = hsum();
        automatic int h = m_pos % ht;
        automatic int v = m_pos / ht;
        automatic int a0 = sh_h[0] + sh_h[1];
        automatic int b0 = sh_v[0] + sh_v[1];
        e_hs = h < sh_h[0];
        e_vs = (m_pos >= sh_dly) && (m_pos < sh_dly + sh_v[0] * ht);
        e_de = (h >= a0) && (h < a0 + sh_h[2]) && (v >= b0) && (v < b0 + sh_v[2]);
        e_pix = e_de && (((h - a0) % (sh_rep + 1)) == 0);
      end
      chk("R1 hsync", hsync, e_hs);
      chk("R2 de", de, e_de);
      chk("R3 vsync", vsync, e_vs);
      chk("R3 field", field, m_field);
      chk("R4 pix_adv", pix_adv, e_pix);
      chk("R7 irq", irq, (m_irqst != 0 && m_irqen != 0));
      chk("R10 fifo_flush", flush, m_flush);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    int waited;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 hsync", hsync, 0); chk("R11 vsync", vsync, 0); chk("R11 de", de, 0);
    chk("R11 irq", irq, 0); chk("R11 flush", flush, 0);
    #1 chk("R11 ctrl readback", rdata, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R12 progressive raster: h 2/3/4/2, v 1/2/3/2
    wr_reg(2, 32'h0003_0002);
    wr_reg(3, 32'h0002_0004);
    wr_reg(4, 32'h0002_0001);
    wr_reg(5, 32'h0002_0003);
    wr_reg(6, 32'h0001_0001);
    wr_reg(7, 32'h0002_0003);
    wr_reg(9, 32'h1);
    rd_reg(3, r); chk("R12 seg readback", r, 32'h0002_0004);
    wr_reg(0, 32'h1);
    wr_reg(1, 32'h3);
    wait_cyc(30);
    rd_reg(1, r); chk("R6 enable reads 1 while running", r[0], 1);
    wait_cyc(150);
    rd_reg(10, r); chk("R7 status set", r[0], 1);
    wr_reg(10, 32'h1);
    rd_reg(10, r); chk("R7 status cleared by W1C", r[0], 0);

    // R8 mid-frame width change, then R4 repeat factor 2
    wait_cyc(20);
    wr_reg(3, 32'h0001_0006);
    wait_cyc(200);
    wr_reg(0, 32'h101);
    wait_cyc(300);

    // R9 thresholds per format
    wr_reg(0, 32'h001);
    level = 7'd51; #1 chk("R9 fmt16 below", full, 0);
    level = 7'd52; #1 chk("R9 fmt16 at", full, 1);
    wr_reg(0, 32'h011);
    level = 7'd49; #1 chk("R9 fmt18 below", full, 0);
    level = 7'd50; #1 chk("R9 fmt18 at", full, 1);
    wr_reg(0, 32'h021);
    level = 7'd45; #1 chk("R9 fmt24 below", full, 0);
    level = 7'd46; #1 chk("R9 fmt24 at", full, 1);
    wr_reg(0, 32'h031);
    level = 7'd45; #1 chk("R9 fmt3 below", full, 0);
    level = 7'd46; #1 chk("R9 fmt3 at", full, 1);

    // R10 explicit flush and clear-at-start
    wr_reg(0, 32'h003);
    chk("R10 flush after clear write", flush, 1);
    wr_reg(0, 32'h005);
    wait_cyc(250);

    // R3 interlace, odd delay 5, even delay 3
    wr_reg(8, 32'h3);
    wr_reg(1, 32'h0005_0007);
    wait_cyc(450);
    rd_reg(1, r); chk("R12 odd delay readback", r[27:16], 5);

    // R6 shutdown: clear enable mid-frame, keep continuous and interlace
    wr_reg(1, 32'h0005_0006);
    rd_reg(1, r); chk("R6 still reads 1 until frame end", r[0], 1);
    waited = 0;
    while (r[0] && waited < 400) begin rd_reg(1, r); waited++; end
    chk("R6 reads 0 after stop", r[0], 0);
    chk("R6 idle hsync", hsync, 0); chk("R6 idle de", de, 0);
    wait_cyc(30);
    chk("R6 stays idle", vsync, 0);

    // R5 single shot, R7 masked interrupt
    wr_reg(9, 32'h0);
    wr_reg(10, 32'h1);
    wr_reg(1, 32'h1);
    wait_cyc(20);
    rd_reg(1, r); chk("R5 single frame running", r[0], 1);
    wait_cyc(160);
    rd_reg(1, r); chk("R5 single frame stopped", r[0], 0);
    chk("R5 idle after one frame", de, 0);
    rd_reg(10, r); chk("R7 status set while masked", r[0], 1);
    chk("R7 irq masked", irq, 0);

    // R2/R1 another continuous progressive run with master gating start
    wr_reg(0, 32'h0);
    wr_reg(1, 32'h3);
    wait_cyc(40);
    chk("R5 master off blocks start", hsync, 0);
    wr_reg(0, 32'h1);
    wait_cyc(200);

    cmp_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule